// File: doc/BRIEF.md
# SAR ADC Serial Capture Controller

This block sits on the host side of a serial successive-approximation converter. It drives the converter's chip select and serial clock and reads the converter's serial data line. After reset it holds chip select high for the converter's power-on interval. It then runs one full conversion whose data is thrown away, because that frame only primes the converter's track-and-hold.

After that, every start request produces one conversion frame. The block delivers the result as a parallel word with a one-cycle valid strobe. A ready flag shows when a request would be served at once. Requests that arrive while the block is busy are held and served as soon as the timing rules allow.

A resolution input trades precision for time. The controller raises chip select right after the last wanted bit and returns a left-aligned, zero-filled partial result. All timing (power-on wait, serial clock half period, acquisition gap) is set in system clock cycles and derived from the clock frequencies.

Top module: `sar_capture_ctrl`

## Requirements
- R1: After reset release, chip select stays high for exactly PWRUP_CYCLES clock cycles. Its first fall comes at the clock edge numbered PWRUP_CYCLES after release.
- R2: The first frame after the power-on wait is a dummy frame. It has the full 16 serial clock rising edges and produces no valid strobe.
- R3: The serial clock idles high whenever chip select is high. Inside a frame its period is 2*HALF_DIV system cycles, with HALF_DIV = CLK_HZ/(2*SCLK_HZ) (at least 1).
- R4: Serial data is sampled on serial clock rising edges, MSB first. Bit positions 1 to 4 of a frame are ignored lead-in bits. Positions 5 to 16 are the 12 result bits. With full resolution, sample_o equals those 12 bits.
- R5: res_i selects the number of result bits N. Values 1 to 11 give N = res_i; 0 and 12 to 15 give 12. Chip select rises right after rising edge 4+N. sample_o holds the N captured bits in its top positions and zeros below.
- R6: Between the end of one frame and the start of the next, chip select stays high for at least ACQ_CYCLES clock cycles (200 ns). This includes the gap after the dummy frame and after shortened frames.
- R7: A start request made during the power-on wait, the dummy frame, a frame or the acquisition gap is held and served once the block is free. Several requests made while busy collapse into one extra frame.
- R8: ready_o is high only when the block is idle with no request pending. It is low during reset, the power-on wait, frames and acquisition gaps.
- R9: res_i is taken when a frame starts. Changing it during the frame has no effect on that frame's length or result.
- R10: valid_o is a single-cycle strobe. It rises at the clock edge where chip select returns high. sample_o holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, one cycle or level |
| res_i | input | 4 | Number of result bits to capture (0 or >12 means 12) |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter, idles high |
| sample_o | output | 12 | Left-aligned conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| ready_o | output | 1 | Idle and able to start a frame at once |

## Verification
Every cycle, the assertions check the following:
- chip select is not lowered inside the power-on interval;
- each fall of chip select is preceded by the acquisition gap;
- the serial clock idles high outside frames;
- the strobe lasts one cycle and only comes with chip select high;
- ready never shows during a frame;
- the edge count never runs past 16.

Only the bench scenarios can show the data path:
- that bits are taken on the right edge and in order;
- that partial results are aligned correctly;
- that the dummy frame yields no result;
- that held requests are served exactly once;
- that a mid-frame change of res_i is ignored.

// File: rtl/sar_capture_pkg.sv
package sar_capture_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FRAME = 2'd2,
    ST_GAP   = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_wait_timer.sv
module sar_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || done_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/sar_sclk_div.sv
module sar_sclk_div #(
  parameter int unsigned HALF_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_rx_shift.sv
module sar_rx_shift #(
  parameter int unsigned RES_BITS  = 12,
  parameter int unsigned LEAD_BITS = 4,
  parameter int unsigned EW        = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                cap_i,
  input  logic [EW-1:0]       bit_idx_i,
  input  logic                sdo_i,
  input  logic                last_i,
  input  logic                keep_i,
  output logic [RES_BITS-1:0] sample_o,
  output logic                valid_o
);
  logic [RES_BITS-1:0] acc_q, acc_nxt;

  // bit_idx_i is the count of rising edges already seen in this frame
  always_comb begin
    acc_nxt = acc_q;
    for (int b = 0; b < RES_BITS; b++) begin
      if (cap_i && bit_idx_i == EW'(LEAD_BITS + b)) acc_nxt[RES_BITS-1-b] = sdo_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      acc_q   <= clear_i ? '0 : acc_nxt;
      valid_o <= last_i && keep_i;
      if (last_i && keep_i) sample_o <= acc_nxt;
    end
  end

  assert_strobe_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/sar_capture_ctrl.sv
module sar_capture_ctrl
  import sar_capture_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned SCLK_HZ      = 10_000_000,
  parameter int unsigned PWRUP_CYCLES = CLK_HZ / 400,        // 2.5 ms
  parameter int unsigned ACQ_CYCLES   = CLK_HZ / 5_000_000,  // 200 ns
  parameter int unsigned RES_BITS     = 12,
  parameter int unsigned LEAD_BITS    = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [$clog2(RES_BITS+1)-1:0]     res_i,
  input  logic                              adc_sdo_i,
  output logic                              adc_cs_no,
  output logic                              adc_sclk_o,
  output logic [RES_BITS-1:0]               sample_o,
  output logic                              valid_o,
  output logic                              ready_o
);
  localparam int unsigned FRAME_BITS = LEAD_BITS + RES_BITS;
  localparam int unsigned RW         = $clog2(RES_BITS + 1);
  localparam int unsigned EW         = $clog2(FRAME_BITS + 1);
  localparam int unsigned HALF_RAW   = CLK_HZ / (2 * SCLK_HZ);
  localparam int unsigned HALF_DIV   = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned MAX_WAIT   = (PWRUP_CYCLES > ACQ_CYCLES) ? PWRUP_CYCLES : ACQ_CYCLES;
  localparam int unsigned TW         = $clog2(MAX_WAIT + 1);

  function automatic logic [EW-1:0] frame_len(input logic [RW-1:0] r);
    if (r == '0 || r > RW'(RES_BITS)) return EW'(FRAME_BITS);
    return EW'(LEAD_BITS) + EW'(r);
  endfunction

  sar_state_e    state_q;
  logic          dummy_q, pend_q, sclk_q;
  logic [EW-1:0] edge_cnt_q, target_q;
  logic          tmr_en, tmr_done, tick, rise_tick, last_rise, start_any;
  logic [TW-1:0] tmr_limit;

  assign tmr_en    = (state_q == ST_PWRUP) || (state_q == ST_GAP);
  assign tmr_limit = (state_q == ST_PWRUP) ? TW'(PWRUP_CYCLES) : TW'(ACQ_CYCLES);
  assign rise_tick = tick && !sclk_q;
  assign last_rise = rise_tick && (edge_cnt_q == target_q - 1'b1);
  assign start_any = start_i || pend_q;

  assign adc_cs_no  = (state_q != ST_FRAME);
  assign adc_sclk_o = sclk_q;
  assign ready_o    = (state_q == ST_IDLE) && !pend_q;

  sar_wait_timer #(.W(TW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tmr_en), .limit_i(tmr_limit), .done_o(tmr_done)
  );

  sar_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(state_q == ST_FRAME), .tick_o(tick)
  );

  sar_rx_shift #(.RES_BITS(RES_BITS), .LEAD_BITS(LEAD_BITS), .EW(EW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(state_q != ST_FRAME), .cap_i(rise_tick),
    .bit_idx_i(edge_cnt_q), .sdo_i(adc_sdo_i), .last_i(last_rise), .keep_i(!dummy_q),
    .sample_o(sample_o), .valid_o(valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PWRUP;
      dummy_q    <= 1'b1;
      pend_q     <= 1'b0;
      sclk_q     <= 1'b1;
      edge_cnt_q <= '0;
      target_q   <= EW'(FRAME_BITS);
    end else begin
      if (start_i && state_q != ST_IDLE) pend_q <= 1'b1;
      unique case (state_q)
        ST_PWRUP: if (tmr_done) begin
          state_q  <= ST_FRAME;
          dummy_q  <= 1'b1;
          target_q <= EW'(FRAME_BITS);
        end
        ST_IDLE: if (start_any) begin
          state_q  <= ST_FRAME;
          dummy_q  <= 1'b0;
          target_q <= frame_len(res_i);
          pend_q   <= 1'b0;
        end
        ST_FRAME: if (tick) begin
          sclk_q <= ~sclk_q;
          if (rise_tick) edge_cnt_q <= edge_cnt_q + 1'b1;
          if (last_rise) begin
            state_q    <= ST_GAP;
            sclk_q     <= 1'b1;
            edge_cnt_q <= '0;
          end
        end
        ST_GAP: if (tmr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker state: cycles since reset, cycles chip select has been high
  logic [TW-1:0] since_rst_q, cs_hi_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= '0;
      cs_hi_q     <= TW'(ACQ_CYCLES);
    end else begin
      if (since_rst_q < TW'(PWRUP_CYCLES)) since_rst_q <= since_rst_q + 1'b1;
      if (!adc_cs_no)                      cs_hi_q <= '0;
      else if (cs_hi_q < TW'(ACQ_CYCLES))  cs_hi_q <= cs_hi_q + 1'b1;
    end
  end

  assert_powerup_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q < TW'(PWRUP_CYCLES)) |-> adc_cs_no);
  assert_acq_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_cs_no) |-> (cs_hi_q >= TW'(ACQ_CYCLES)));
  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no |-> adc_sclk_o);
  assert_valid_at_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (adc_cs_no && $rose(adc_cs_no)));
  assert_ready_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (adc_cs_no && !valid_o));
  assert_edge_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_cnt_q < EW'(FRAME_BITS));
endmodule

// File: tb/sar_capture_ctrl_test.sv
module sar_capture_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PWR        = 40;
  localparam int ACQ        = 20;
  localparam int HALF       = 5;
  localparam int WD_CYCLES  = 60000;

  // {res[27:24], adc value[23:12], expected sample[11:0]}
  localparam logic [27:0] VEC [9] = '{
    {4'd12, 12'hABC, 12'hABC},
    {4'd8,  12'hABC, 12'hAB0},
    {4'd1,  12'hFFF, 12'h800},
    {4'd0,  12'h5A5, 12'h5A5},
    {4'd15, 12'h123, 12'h123},
    {4'd4,  12'h9F7, 12'h900},
    {4'd11, 12'hFFF, 12'hFFE},
    {4'd12, 12'h000, 12'h000},
    {4'd6,  12'h3C3, 12'h3C0}
  };

  logic        clk = 1'b0;
  logic        rst_ni, start_i, adc_sdo_i;
  logic [3:0]  res_i;
  logic        adc_cs_no, adc_sclk_o, valid_o, ready_o;
  logic [11:0] sample_o;
  logic [11:0] adc_val;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_capture_ctrl #(.CLK_HZ(100_000_000), .SCLK_HZ(10_000_000), .PWRUP_CYCLES(PWR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .res_i(res_i), .adc_sdo_i(adc_sdo_i),
    .adc_cs_no(adc_cs_no), .adc_sclk_o(adc_sclk_o), .sample_o(sample_o),
    .valid_o(valid_o), .ready_o(ready_o)
  );

  // converter model: lead-in bits 1010, then value MSB first, launched on SCLK fall
  logic [15:0] cur_word;
  int          bit_idx;
  initial adc_sdo_i = 1'b0;
  always @(negedge adc_cs_no) begin
    cur_word = {4'b1010, adc_val};
    bit_idx  = 0;
  end
  always @(negedge adc_sclk_o) begin
    if (!adc_cs_no && bit_idx < 16) begin
      adc_sdo_i = cur_word[15 - bit_idx];
      bit_idx++;
    end
  end

  // monitor
  int mcyc = 0, rise_cnt = 0, last_edges = 0, frame_cnt = 0, hi_len = 0;
  int min_gap = 1000000, gap_seen = 0, valid_cnt = 0, long_valid = 0;
  int last_rise = 0, pmin = 1000000, pmax = 0;
  logic [11:0] last_sample = '0;
  logic p_cs = 1'b1, p_sclk = 1'b1, p_valid = 1'b0;
  always @(posedge clk) begin
    if (rst_ni) begin
      automatic bit rise = adc_sclk_o && !p_sclk;
      mcyc <= mcyc + 1;
      p_cs <= adc_cs_no; p_sclk <= adc_sclk_o; p_valid <= valid_o;
      if (rise && rise_cnt != 0) begin
        if (mcyc - last_rise < pmin) pmin <= mcyc - last_rise;
        if (mcyc - last_rise > pmax) pmax <= mcyc - last_rise;
      end
      if (rise) last_rise <= mcyc;
      if (adc_cs_no && !p_cs) begin
        last_edges <= rise_cnt + (rise ? 1 : 0);
        rise_cnt   <= 0;
        frame_cnt  <= frame_cnt + 1;
      end else if (rise) rise_cnt <= rise_cnt + 1;
      if (adc_cs_no) hi_len <= hi_len + 1;
      else if (p_cs) begin
        if (frame_cnt > 0) begin
          gap_seen <= gap_seen + 1;
          if (hi_len < min_gap) min_gap <= hi_len;
        end
        hi_len <= 0;
      end
      if (valid_o) begin
        valid_cnt   <= valid_cnt + 1;
        last_sample <= sample_o;
        if (p_valid) long_valid <= long_valid + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_valid();
    int n0 = valid_cnt;
    while (valid_cnt == n0) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready_o) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int k_fall = 0;
    rst_ni = 1'b0; start_i = 1'b0; res_i = 4'd12; adc_val = 12'hFFF;
    repeat (3) @(negedge clk);
    check("R1 cs idle in reset", adc_cs_no, 1);
    check("R3 sclk idle in reset", adc_sclk_o, 1);
    check("R10 valid in reset", valid_o, 0);
    check("R8 ready in reset", ready_o, 0);
    check("R10 sample in reset", sample_o, 0);
    rst_ni = 1'b1;

    // power-on wait, with a request held from inside it
    for (int k = 1; k < 1000; k++) begin
      @(negedge clk);
      if (k == 5) begin
        check("R8 ready during powerup", ready_o, 0);
        start_i = 1'b1;
      end else start_i = 1'b0;
      if (!adc_cs_no) begin k_fall = k; break; end
    end
    check("R1 first cs fall cycle", k_fall, PWR);

    // dummy frame
    while (frame_cnt < 1) @(negedge clk);
    check("R2 dummy frame edges", last_edges, 16);
    check("R2 dummy frame no valid", valid_cnt, 0);
    adc_val = 12'h6D2;
    wait_valid();
    check("R7 request from powerup served", last_sample, 12'h6D2);
    check("R4 full frame edges", last_edges, 16);

    // vector table
    foreach (VEC[i]) begin
      automatic int r   = VEC[i][27:24];
      automatic int eff = (r == 0 || r > 12) ? 12 : r;
      wait_ready();
      adc_val = VEC[i][23:12];
      res_i   = VEC[i][27:24];
      pulse_start();
      wait_valid();
      check(eff == 12 ? "R4 sample" : "R5 sample", last_sample, VEC[i][11:0]);
      check("R5 edge count", last_edges, 4 + eff);
      check("R10 sample held", sample_o, VEC[i][11:0]);
    end

    // resolution change mid-frame ignored
    wait_ready();
    adc_val = 12'h7E1; res_i = 4'd12;
    pulse_start();
    repeat (30) @(negedge clk);
    res_i = 4'd2;
    wait_valid();
    check("R9 sample with late res change", last_sample, 12'h7E1);
    check("R9 edges with late res change", last_edges, 16);

    // request during acquisition gap
    check("R8 ready during gap", ready_o, 0);
    adc_val = 12'h0F0; res_i = 4'd12;
    pulse_start();
    wait_valid();
    check("R7 request from gap served", last_sample, 12'h0F0);

    // several requests while busy collapse into one
    begin
      int n0;
      wait_ready();
      n0 = valid_cnt;
      adc_val = 12'h555;
      pulse_start();
      repeat (40) @(negedge clk);
      pulse_start();
      repeat (20) @(negedge clk);
      pulse_start();
      wait_valid();
      wait_valid();
      repeat (400) @(negedge clk);
      check("R7 collapsed requests", valid_cnt - n0, 2);
      check("R8 ready after drain", ready_o, 1);
    end

    check("R6 gaps observed", gap_seen > 10, 1);
    check("R6 min acquisition gap", min_gap >= ACQ, 1);
    check("R3 sclk min period", pmin, 2 * HALF);
    check("R3 sclk max period", pmax, 2 * HALF);
    check("R10 single-cycle strobe", long_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule